// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between per-class ready queues and the execution units of an out-of-order core. Each instruction class has its own small age-ordered queue of ready instructions, identified by sequence number, and one execution unit. In every cycle the selector looks at the head of each queue. It skips classes whose unit is still reserved and classes whose head has been squashed. From the classes that remain it grants the ones with the smallest head sequence numbers, up to the issue width.

Granted instructions fill an issue bundle in age order, starting at slot 0. Each class has a parameter that sets its issue latency. A class with latency one can issue again in the next cycle. A class with a longer latency keeps its unit reserved, and the instruction is handed to execute on a separate per-class delivery output, latency minus one cycles after it was granted. A squash input marks every queued entry younger than a given sequence number as dead. A dead head is popped without using an issue slot, and the next entry of that class competes in the following cycle.

Top module: `iq_issue_select`

## Requirements
- R1: Among the classes eligible in a cycle (head present, head not dead, unit free), the granted ones are those with the smallest head sequence numbers. Slot 0 carries the oldest, and later slots carry non-decreasing sequence numbers. Equal numbers are resolved toward the lower class index.
- R2: At most WIDTH instructions are granted per cycle and at most one per class. Valid slots are packed from slot 0 upward with no gaps, and each slot reports the sequence number and class index of its instruction.
- R3: A dead head is never granted. It is removed in the cycle it is seen, without using a slot, and the class's next entry competes from the following cycle.
- R4: A class whose unit is busy is not granted, and the free slot goes to the next-oldest eligible class.
- R5: A class with issue latency 1 never shows busy and can be granted in consecutive cycles.
- R6: When a class with latency L>1 is granted in cycle t, unit_busy_o for that class is high from t+1 through t+L-1. deliver_valid_o is high in cycle t+L-1 with the granted sequence number. The class may be granted again from t+L.
- R7: When squash_i is high, every entry held or pushed that cycle whose sequence number is strictly greater than squash_seq_i becomes dead. Entries with smaller or equal numbers are unaffected.
- R8: Each class queue holds DEPTH entries in push order, and full_o is high when it holds DEPTH entries. A push while full_o is high is ignored: that sequence number is never issued.
- R9: active_o is high exactly in the cycles in which at least one slot is valid.
- R10: After reset all queues are empty, no unit is busy, and no slot, delivery or activity output is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | NCLS | Per-class push strobe |
| push_seq_i | input | NCLS*16 | Per-class pushed sequence number (class c at bits c*16 +: 16) |
| full_o | output | NCLS | Per-class queue full |
| squash_i | input | 1 | Squash strobe |
| squash_seq_i | input | 16 | Entries with a larger sequence number become dead |
| slot_valid_o | output | WIDTH | Issue bundle slot valid |
| slot_seq_o | output | WIDTH*16 | Sequence number per slot |
| slot_cls_o | output | WIDTH*CLS_W | Class index per slot |
| unit_busy_o | output | NCLS | Per-class unit reserved |
| deliver_valid_o | output | NCLS | Per-class delayed hand-off to execute |
| deliver_seq_o | output | NCLS*16 | Sequence number of the delayed hand-off |
| active_o | output | 1 | At least one instruction issued this cycle |

## Verification
A wrong head pointer or a stale dead bit shows up in the bundle of the same cycle as a wrong sequence number, a wrong class, or an issued squashed number. A bad reservation counter shows up as a busy flag that is off by a cycle, or as a delivery pulse that is early, late or missing, within L cycles of the grant. Queue occupancy errors appear on full_o. A dropped or duplicated entry shows up as soon as that class's queue drains through the bundle. The bench therefore checks every output on every cycle against a model of queues and timers, under random pushes and squashes with latencies 1, 2 and 4.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;
  localparam int SEQ_W = 16;
  localparam int LAT_W = 4;
  typedef logic [SEQ_W-1:0] seq_t;

  // a wins over b: smaller sequence, ties to lower class index
  function automatic logic beats(seq_t a, int unsigned ia, seq_t b, int unsigned ib);
    return (a < b) || ((a == b) && (ia < ib));
  endfunction
endpackage

// File: rtl/iq_class_fifo.sv
module iq_class_fifo import iq_sel_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  seq_t push_seq_i,
  input  logic pop_i,
  input  logic squash_i,
  input  seq_t squash_seq_i,
  output logic head_valid_o,
  output seq_t head_seq_o,
  output logic head_dead_o,
  output logic full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  seq_t             seq_q [DEPTH];
  logic [DEPTH-1:0] dead_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o       = (cnt_q == CNT_W'(DEPTH));
  assign head_valid_o = (cnt_q != '0);
  assign head_seq_o   = seq_q[rd_q];
  assign head_dead_o  = dead_q[rd_q];
  assign push_ok      = push_i && !full_o;
  assign pop_ok       = pop_i && head_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      dead_q <= '0;
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_ok && (wr_q == PTR_W'(i))) begin
          seq_q[i]  <= push_seq_i;
          dead_q[i] <= squash_i && (push_seq_i > squash_seq_i);
        end else if (squash_i && (seq_q[i] > squash_seq_i)) begin
          dead_q[i] <= 1'b1;
        end
      end
      if (push_ok) wr_q <= wr_q + PTR_W'(1);
      if (pop_ok)  rd_q <= rd_q + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_pop_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/iq_unit_timer.sv
module iq_unit_timer import iq_sel_pkg::*; #(
  parameter int LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  seq_t issue_seq_i,
  output logic busy_o,
  output logic deliver_o,
  output seq_t deliver_seq_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  seq_t             seq_q;

  assign busy_o        = (cnt_q != '0);
  assign deliver_o     = (cnt_q == CNT_W'(1));
  assign deliver_seq_o = seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      seq_q <= '0;
    end else if (issue_i) begin
      cnt_q <= CNT_W'(LAT - 1);
      seq_q <= issue_seq_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_free_at_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (cnt_q == '0));
  assert_reserve_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (cnt_q == CNT_W'(LAT - 1)) && (seq_q == $past(issue_seq_i)));
endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick import iq_sel_pkg::*; #(
  parameter int NCLS  = 4,
  parameter int WIDTH = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NCLS-1:0]                  cand_i,
  input  logic [NCLS-1:0][SEQ_W-1:0]       seq_i,
  output logic [NCLS-1:0]                  grant_o,
  output logic [WIDTH-1:0]                 slot_valid_o,
  output logic [WIDTH-1:0][SEQ_W-1:0]      slot_seq_o,
  output logic [WIDTH-1:0][((NCLS>1)?$clog2(NCLS):1)-1:0] slot_cls_o
);
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1;
  localparam int RANK_W = $clog2(NCLS + 1);

  logic [NCLS-1:0][RANK_W-1:0] rank;

  // rank = number of eligible classes that beat this one
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      rank[c] = '0;
      for (int d = 0; d < NCLS; d++)
        if (d != c && cand_i[d] && beats(seq_i[d], d, seq_i[c], c))
          rank[c] = rank[c] + RANK_W'(1);
      grant_o[c] = cand_i[c] && (rank[c] < RANK_W'(WIDTH));
    end
  end

  always_comb begin
    for (int s = 0; s < WIDTH; s++) begin
      slot_valid_o[s] = 1'b0;
      slot_seq_o[s]   = '0;
      slot_cls_o[s]   = '0;
      for (int c = 0; c < NCLS; c++)
        if (grant_o[c] && rank[c] == RANK_W'(s)) begin
          slot_valid_o[s] = 1'b1;
          slot_seq_o[s]   = seq_i[c];
          slot_cls_o[s]   = CLS_W'(c);
        end
    end
  end

  assert_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) <= WIDTH);
  assert_slots_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_valid_o) == $countones(grant_o));

  for (genvar s = 1; s < WIDTH; s++) begin : g_order
    assert_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_valid_o[s] |-> slot_valid_o[s-1] && (slot_seq_o[s-1] <= slot_seq_o[s]));
  end
endmodule

// File: rtl/iq_issue_select.sv
module iq_issue_select import iq_sel_pkg::*; #(
  parameter int                      NCLS    = 4,
  parameter int                      DEPTH   = 4,
  parameter int                      WIDTH   = 2,
  parameter logic [NCLS*LAT_W-1:0]   LAT_VEC = {4'd4, 4'd2, 4'd1, 4'd1},
  parameter int                      CLS_W   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCLS-1:0]           push_valid_i,
  input  logic [NCLS*SEQ_W-1:0]     push_seq_i,
  output logic [NCLS-1:0]           full_o,
  input  logic                      squash_i,
  input  logic [SEQ_W-1:0]          squash_seq_i,
  output logic [WIDTH-1:0]          slot_valid_o,
  output logic [WIDTH*SEQ_W-1:0]    slot_seq_o,
  output logic [WIDTH*CLS_W-1:0]    slot_cls_o,
  output logic [NCLS-1:0]           unit_busy_o,
  output logic [NCLS-1:0]           deliver_valid_o,
  output logic [NCLS*SEQ_W-1:0]     deliver_seq_o,
  output logic                      active_o
);
  logic [NCLS-1:0]             head_valid, head_dead, busy, cand, grant, pop;
  logic [NCLS-1:0][SEQ_W-1:0]  head_seq;
  logic [WIDTH-1:0][SEQ_W-1:0] slot_seq;
  logic [WIDTH-1:0][CLS_W-1:0] slot_cls;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam int LAT = int'(LAT_VEC[c*LAT_W +: LAT_W]);

    assign cand[c] = head_valid[c] && !head_dead[c] && !busy[c];
    assign pop[c]  = grant[c] || (head_valid[c] && head_dead[c]);

    iq_class_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_i       (push_valid_i[c]),
      .push_seq_i   (push_seq_i[c*SEQ_W +: SEQ_W]),
      .pop_i        (pop[c]),
      .squash_i     (squash_i),
      .squash_seq_i (squash_seq_i),
      .head_valid_o (head_valid[c]),
      .head_seq_o   (head_seq[c]),
      .head_dead_o  (head_dead[c]),
      .full_o       (full_o[c])
    );

    iq_unit_timer #(.LAT(LAT)) u_timer (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .issue_i       (grant[c]),
      .issue_seq_i   (head_seq[c]),
      .busy_o        (busy[c]),
      .deliver_o     (deliver_valid_o[c]),
      .deliver_seq_o (deliver_seq_o[c*SEQ_W +: SEQ_W])
    );

    assert_dead_skipped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      head_dead[c] |-> !grant[c]);
    if (LAT <= 1) begin : g_fast
      assert_never_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy[c]);
    end
  end

  iq_age_pick #(.NCLS(NCLS), .WIDTH(WIDTH)) u_pick (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cand_i       (cand),
    .seq_i        (head_seq),
    .grant_o      (grant),
    .slot_valid_o (slot_valid_o),
    .slot_seq_o   (slot_seq),
    .slot_cls_o   (slot_cls)
  );

  assign slot_seq_o  = slot_seq;
  assign slot_cls_o  = slot_cls;
  assign unit_busy_o = busy;
  assign active_o    = |slot_valid_o;

  assert_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (grant != '0));
endmodule

// File: tb/iq_issue_select_tb_top.sv
`timescale 1ns/1ps
module iq_issue_select_tb_top;
  localparam int NCLS = 4, DEPTH = 4, WIDTH = 2, SW = 16, CW = 2;
  localparam int LAT [NCLS] = '{1, 1, 2, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCLS-1:0]    push_valid = '0;
  logic [NCLS*SW-1:0] push_seq = '0;
  logic               squash = 1'b0;
  logic [SW-1:0]      squash_seq = '0;
  logic [NCLS-1:0]    full, busy, dvalid;
  logic [WIDTH-1:0]   svalid;
  logic [WIDTH*SW-1:0] sseq;
  logic [WIDTH*CW-1:0] scls;
  logic [NCLS*SW-1:0] dseq;
  logic               active;

  always #2.5 clk = ~clk;

  iq_issue_select dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_seq_i(push_seq),
    .full_o(full), .squash_i(squash), .squash_seq_i(squash_seq),
    .slot_valid_o(svalid), .slot_seq_o(sseq), .slot_cls_o(scls),
    .unit_busy_o(busy), .deliver_valid_o(dvalid), .deliver_seq_o(dseq), .active_o(active)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // model state
  int m_seq [NCLS][DEPTH];
  bit m_dead[NCLS][DEPTH];
  int m_cnt [NCLS];
  int m_tmr [NCLS];
  int m_dsq [NCLS];
  int nxt_seq = 1;
  // directed bookkeeping
  int run0 = 0, max_run0 = 0;
  bit saw4 = 0, saw6 = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_cand(int c);
    return m_cnt[c] > 0 && !m_dead[c][0] && m_tmr[c] == 0;
  endfunction

  // one cycle: check outputs at negedge, drive inputs, advance model
  task automatic step(input logic [NCLS-1:0] pmask, input bit sq, input int sqseq);
    bit g [NCLS];
    int rk [NCLS];
    logic [WIDTH-1:0] ev;
    logic [NCLS-1:0] eb, ed, ef;
    bit fpre [NCLS];
    bit any0;
    @(negedge clk);
    ev = '0;
    for (int c = 0; c < NCLS; c++) begin
      rk[c] = 0;
      for (int d = 0; d < NCLS; d++)
        if (d != c && is_cand(d) && m_seq[d][0] < m_seq[c][0]) rk[c]++;
      g[c] = is_cand(c) && rk[c] < WIDTH;
      if (g[c]) ev[rk[c]] = 1'b1;
      eb[c] = m_tmr[c] != 0;
      ed[c] = m_tmr[c] == 1;
      ef[c] = m_cnt[c] == DEPTH;
    end
    chk(svalid == ev, "R2 slot_valid", svalid, ev);
    for (int c = 0; c < NCLS; c++) if (g[c]) begin
      chk(sseq[rk[c]*SW +: SW] == SW'(m_seq[c][0]), "R1 slot seq", sseq[rk[c]*SW +: SW], m_seq[c][0]);
      chk(scls[rk[c]*CW +: CW] == CW'(c), "R1 slot class", scls[rk[c]*CW +: CW], c);
    end
    for (int c = 0; c < NCLS; c++)
      if (m_cnt[c] > 0 && m_dead[c][0])
        for (int s = 0; s < WIDTH; s++)
          chk(!(svalid[s] && scls[s*CW +: CW] == CW'(c)), "R3 dead head issued", c, -1);
    chk(busy == eb, "R4 R6 unit_busy", busy, eb);
    chk(dvalid == ed, "R6 deliver_valid", dvalid, ed);
    for (int c = 0; c < NCLS; c++) if (ed[c])
      chk(dseq[c*SW +: SW] == SW'(m_dsq[c]), "R6 deliver seq", dseq[c*SW +: SW], m_dsq[c]);
    chk(full == ef, "R8 full", full, ef);
    chk(active == (ev != '0), "R9 active", active, ev != '0);
    any0 = 0;
    for (int s = 0; s < WIDTH; s++) if (svalid[s]) begin
      if (scls[s*CW +: CW] == 0) any0 = 1;
      if (sseq[s*SW +: SW] == 4) saw4 = 1;
      if (sseq[s*SW +: SW] == 6) saw6 = 1;
    end
    run0 = any0 ? run0 + 1 : 0;
    if (run0 > max_run0) max_run0 = run0;
    // drive
    push_valid = pmask;
    for (int c = 0; c < NCLS; c++) begin
      push_seq[c*SW +: SW] = SW'(nxt_seq);
      if (pmask[c]) nxt_seq++;
    end
    squash = sq;
    squash_seq = SW'(sqseq);
    // advance model
    for (int c = 0; c < NCLS; c++) begin
      fpre[c] = m_cnt[c] == DEPTH;
      if (m_cnt[c] > 0 && (g[c] || m_dead[c][0])) begin
        for (int i = 0; i < DEPTH-1; i++) begin
          m_seq[c][i] = m_seq[c][i+1];
          m_dead[c][i] = m_dead[c][i+1];
        end
        m_cnt[c]--;
      end
      if (g[c] && LAT[c] > 1) begin
        m_tmr[c] = LAT[c] - 1;
        m_dsq[c] = m_seq[c][0];
      end else if (m_tmr[c] > 0) m_tmr[c]--;
      if (g[c] && LAT[c] > 1) m_dsq[c] = int'(sseq[rk[c]*SW +: SW]);
      if (pmask[c] && !fpre[c]) begin
        m_seq[c][m_cnt[c]] = int'(push_seq[c*SW +: SW]);
        m_dead[c][m_cnt[c]] = 0;
        m_cnt[c]++;
      end
      if (sq) for (int i = 0; i < m_cnt[c]; i++)
        if (m_seq[c][i] > sqseq) m_dead[c][i] = 1;
    end
  endtask

  initial begin
    for (int c = 0; c < NCLS; c++) begin
      m_cnt[c] = 0; m_tmr[c] = 0; m_dsq[c] = 0;
    end
    void'($urandom(32'd7731));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(svalid == '0 && active == 1'b0, "R10 reset slots", {svalid, active}, 0);
    chk(busy == '0 && dvalid == '0 && full == '0, "R10 reset units", {busy, dvalid, full}, 0);
    rst_n = 1'b1;
    // directed: seq1 c0, seq2 c3, seq3 c0, seq4 c3, seq5 c0, seq6 c3 (squashed above 5)
    step(4'b1001, 0, 0);
    step(4'b1001, 0, 0);
    step(4'b1001, 1, 5);
    repeat (10) step(4'b0000, 0, 0);
    chk(max_run0 >= 3, "R5 back-to-back class0", max_run0, 3);
    chk(saw4 == 1'b1, "R7 older entry kept", saw4, 1);
    chk(saw6 == 1'b0, "R7 younger entry squashed", saw6, 0);
    // fill class 2 (latency 2) past capacity
    repeat (8) step(4'b0100, 0, 0);
    repeat (12) step(4'b0000, 0, 0);
    // random
    for (int k = 0; k < 3000; k++) begin
      logic [NCLS-1:0] pm;
      bit sq;
      int ss;
      pm = NCLS'($urandom) | NCLS'($urandom & 32'h5);
      sq = ($urandom % 20) == 0;
      ss = nxt_seq - 1 - int'($urandom % 6);
      if (ss < 0) ss = 0;
      step(pm, sq, ss);
    end
    repeat (40) step(4'b0000, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule